// File: doc/BRIEF.md
# Single-Wire Bus Master

This block is the master side of a single-wire serial bus in which every device shares one open-drain line held high by an external resistor. A host hands it one command at a time: a bus reset with presence detection, a single-bit write or read, or an eight-bit write or read. The block turns each command into timed low pulses on the line and samples the line at fixed offsets inside each pulse window. The pad driver is external. `line_pull` is the enable of a driver whose data input is tied low, and `line_in` is the level read back from the pad.

All durations are counted in microseconds. A divider turns the system clock into a one-microsecond tick. The divider restarts at the start of every slot, so each pulse is an exact multiple of the clock period with no phase error left over from the previous command. Commands enter through a valid/ready pair. Completion is reported by a single-cycle response pulse that carries the read data or the presence result.

Top module: `ow_master`

## Requirements
- R1: A reset command (op code 0) pulls the line low for exactly 480 µs, then releases it. `busy` falls 240 µs after the release.
- R2: After a reset release, the line is sampled once per microsecond from 60 µs to 240 µs. A low seen at any of these samples returns `rsp_presence`=1. A low that ends before 60 µs returns 0.
- R3: A bit write (op code 1) sends `cmd_data[0]`. A 1 pulls the line low for 6 µs. A 0 pulls it low for 60 µs.
- R4: Every bit slot spans 60 µs and is followed by at least 1 µs with the line released. The next slot of the same command then begins within one extra clock.
- R5: A bit read (op code 2) pulls the line low for 6 µs and samples the line 15 µs after the slot starts. The sampled value is returned in `rsp_data[0]`, with the upper bits zero.
- R6: Byte write (op code 3) and byte read (op code 4) run eight slots, least-significant bit first. A byte read returns the assembled byte in `rsp_data`.
- R7: The line is only ever pulled low or released. `line_pull` is 0 whenever `busy` is 0.
- R8: `cmd_ready` is high exactly when `busy` is low. `busy` rises in the cycle after a command is accepted. `rsp_valid` is a one-cycle pulse in the first cycle that `busy` is low again.
- R9: Op codes 5, 6 and 7 are consumed without effect: no slot, no `busy`, no response.
- R10: While `rst_n` is low and right after it rises, `line_pull`=0, `busy`=0, `rsp_valid`=0 and `cmd_ready`=1.
- R11: Every duration is its microsecond count times `CLKS_PER_US` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Op code (0 reset, 1 write bit, 2 read bit, 3 write byte, 4 read byte) |
| cmd_data | input | 8 | Write data; bit 0 for bit writes |
| busy | output | 1 | Command in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 8 | Read result (zero for writes and reset) |
| rsp_presence | output | 1 | Presence result of a reset |
| line_in | input | 1 | Level read back from the bus pad |
| line_pull | output | 1 | 1 pulls the bus low, 0 releases it |

## Verification
The bench builds the block with `CLKS_PER_US`=4 and keeps the default microsecond timings and the two-stage input synchronizer. At four clocks per microsecond, a full reset with its presence window takes about 2,900 cycles and a byte takes about 2,000 cycles. Several resets, bit and byte transfers therefore fit in one run, and every pulse width can still be compared exactly in clocks. A behavioural device on the line answers presence at an early, a mid-window and a late-window offset, and drives read bits. This exercises the edges of the presence window and the 15 µs sample point against real line levels.

// File: rtl/ow_pkg.sv
package ow_pkg;

  localparam int unsigned BYTE_W = 8;

  localparam logic [2:0] OPC_RESET      = 3'd0;
  localparam logic [2:0] OPC_WRITE_BIT  = 3'd1;
  localparam logic [2:0] OPC_READ_BIT   = 3'd2;
  localparam logic [2:0] OPC_WRITE_BYTE = 3'd3;
  localparam logic [2:0] OPC_READ_BYTE  = 3'd4;

  typedef enum logic [1:0] {
    SLOT_RST = 2'd0,
    SLOT_W0  = 2'd1,
    SLOT_W1  = 2'd2,
    SLOT_RD  = 2'd3
  } slot_kind_e;

  function automatic logic op_known(input logic [2:0] op);
    return op <= OPC_READ_BYTE;
  endfunction

  function automatic logic op_is_byte(input logic [2:0] op);
    return (op == OPC_WRITE_BYTE) || (op == OPC_READ_BYTE);
  endfunction

  function automatic logic op_is_read(input logic [2:0] op);
    return (op == OPC_READ_BIT) || (op == OPC_READ_BYTE);
  endfunction

  // Slot flavour for an op and the data bit to be written next.
  function automatic slot_kind_e kind_for(input logic [2:0] op, input logic wbit);
    if (op == OPC_RESET)  return SLOT_RST;
    if (op_is_read(op))   return SLOT_RD;
    return wbit ? SLOT_W1 : SLOT_W0;
  endfunction

  // Microseconds the line is held low in a slot of the given flavour.
  function automatic int unsigned low_us(input slot_kind_e k, input int unsigned rst_low,
                                         input int unsigned slot, input int unsigned short_low);
    case (k)
      SLOT_RST: return rst_low;
      SLOT_W0:  return slot;
      default:  return short_low;
    endcase
  endfunction

  // Microseconds from slot start until the engine reports completion.
  function automatic int unsigned total_us(input slot_kind_e k, input int unsigned rst_low,
                                           input int unsigned pres_hi, input int unsigned slot,
                                           input int unsigned rec);
    return (k == SLOT_RST) ? (rst_low + pres_hi) : (slot + rec);
  endfunction

  // Received bits enter at the top so the first bit ends in bit 0.
  function automatic logic [BYTE_W-1:0] lsb_first_in(input logic [BYTE_W-1:0] sr, input logic b);
    return {b, sr[BYTE_W-1:1]};
  endfunction

endpackage

// File: rtl/ow_tick_div.sv
module ow_tick_div #(
  parameter int unsigned CLKS_PER_US = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic tick
);
  localparam int unsigned DIV_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(CLKS_PER_US - 1);

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear || (cnt_q == LAST)) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assign tick = (cnt_q == LAST) && !clear;
endmodule

// File: rtl/ow_slot_engine.sv
module ow_slot_engine import ow_pkg::*; #(
  parameter int unsigned T_RST_LOW = 480,
  parameter int unsigned T_PRES_LO = 60,
  parameter int unsigned T_PRES_HI = 240,
  parameter int unsigned T_SLOT    = 60,
  parameter int unsigned T_SHORT   = 6,
  parameter int unsigned T_SAMPLE  = 15,
  parameter int unsigned T_REC     = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  slot_kind_e kind,
  input  logic       tick,
  input  logic       line_lvl,
  output logic       pull,
  output logic       done,
  output logic       bit_smp,
  output logic       pres
);
  localparam int unsigned US_W = $clog2(T_RST_LOW + T_PRES_HI + T_SLOT + T_REC + 2);
  localparam logic [US_W-1:0] SMP_AT = US_W'(T_SAMPLE);
  localparam logic [US_W-1:0] WIN_LO = US_W'(T_RST_LOW + T_PRES_LO);
  localparam logic [US_W-1:0] WIN_HI = US_W'(T_RST_LOW + T_PRES_HI);

  logic            run_q;
  slot_kind_e      kind_q;
  logic [US_W-1:0] us_q;
  logic [US_W-1:0] us_nxt;
  logic [US_W-1:0] low_lim;
  logic [US_W-1:0] end_lim;
  logic            in_window;

  assign us_nxt    = us_q + US_W'(1);
  assign low_lim   = US_W'(low_us(kind_q, T_RST_LOW, T_SLOT, T_SHORT));
  assign end_lim   = US_W'(total_us(kind_q, T_RST_LOW, T_PRES_HI, T_SLOT, T_REC));
  assign in_window = (kind_q == SLOT_RST) && (us_nxt > WIN_LO) && (us_nxt <= WIN_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      kind_q  <= SLOT_W1;
      us_q    <= '0;
      pull    <= 1'b0;
      done    <= 1'b0;
      bit_smp <= 1'b0;
      pres    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        run_q   <= 1'b1;
        kind_q  <= kind;
        us_q    <= '0;
        pull    <= 1'b1;
        bit_smp <= 1'b0;
        pres    <= 1'b0;
      end else if (run_q && tick) begin
        us_q <= us_nxt;
        if (us_nxt == low_lim) pull <= 1'b0;
        if ((kind_q == SLOT_RD) && (us_nxt == SMP_AT)) bit_smp <= line_lvl;
        if (in_window && !line_lvl) pres <= 1'b1;
        if (us_nxt == end_lim) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ow_cmd_ctrl.sv
module ow_cmd_ctrl import ow_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [BYTE_W-1:0] cmd_data,
  output logic              cmd_ready,
  output logic              busy,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_data,
  output logic              rsp_presence,
  output logic              slot_start,
  output slot_kind_e        slot_kind,
  input  logic              slot_done,
  input  logic              slot_bit,
  input  logic              slot_pres
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);

  logic              busy_q;
  logic [2:0]        op_q;
  logic [BYTE_W-1:0] sr_q;
  logic [BYTE_W-1:0] sr_nxt;
  logic [CNT_W-1:0]  left_q;
  logic              launch;
  logic              last_slot;
  logic              cont;

  assign cmd_ready = !busy_q;
  assign busy      = busy_q;
  assign launch    = cmd_valid && !busy_q && op_known(cmd_op);
  assign last_slot = (left_q == CNT_W'(1));
  assign cont      = busy_q && slot_done && !last_slot;
  assign sr_nxt    = lsb_first_in(sr_q, slot_bit);

  assign slot_start = launch || cont;
  assign slot_kind  = launch ? kind_for(cmd_op, cmd_data[0]) : kind_for(op_q, sr_nxt[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q       <= 1'b0;
      op_q         <= OPC_RESET;
      sr_q         <= '0;
      left_q       <= '0;
      rsp_valid    <= 1'b0;
      rsp_data     <= '0;
      rsp_presence <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (launch) begin
        busy_q <= 1'b1;
        op_q   <= cmd_op;
        sr_q   <= cmd_data;
        left_q <= op_is_byte(cmd_op) ? CNT_W'(BYTE_W) : CNT_W'(1);
      end else if (busy_q && slot_done) begin
        sr_q   <= sr_nxt;
        left_q <= left_q - CNT_W'(1);
        if (last_slot) begin
          busy_q       <= 1'b0;
          rsp_valid    <= 1'b1;
          rsp_presence <= (op_q == OPC_RESET) && slot_pres;
          if (!op_is_read(op_q))     rsp_data <= '0;
          else if (op_is_byte(op_q)) rsp_data <= sr_nxt;
          else                       rsp_data <= BYTE_W'(slot_bit);
        end
      end
    end
  end
endmodule

// File: rtl/ow_master.sv
module ow_master import ow_pkg::*; #(
  parameter int unsigned CLKS_PER_US = 125,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned T_RST_LOW   = 480,
  parameter int unsigned T_PRES_LO   = 60,
  parameter int unsigned T_PRES_HI   = 240,
  parameter int unsigned T_SLOT      = 60,
  parameter int unsigned T_SHORT     = 6,
  parameter int unsigned T_SAMPLE    = 15,
  parameter int unsigned T_REC       = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [BYTE_W-1:0] cmd_data,
  output logic              busy,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_data,
  output logic              rsp_presence,
  input  logic              line_in,
  output logic              line_pull
);
  // Named internal events, visible to the bound checker.
  logic       us_tick;
  logic       slot_start;
  slot_kind_e slot_kind;
  logic       slot_done;
  logic       slot_bit;
  logic       slot_pres;
  logic       line_lvl;

  logic [SYNC_STAGES-1:0] sync_q;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= line_in;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
      end
    end
  endgenerate

  assign line_lvl = sync_q[SYNC_STAGES-1];

  ow_tick_div #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (slot_start),
    .tick  (us_tick)
  );

  ow_cmd_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_data     (cmd_data),
    .cmd_ready    (cmd_ready),
    .busy         (busy),
    .rsp_valid    (rsp_valid),
    .rsp_data     (rsp_data),
    .rsp_presence (rsp_presence),
    .slot_start   (slot_start),
    .slot_kind    (slot_kind),
    .slot_done    (slot_done),
    .slot_bit     (slot_bit),
    .slot_pres    (slot_pres)
  );

  ow_slot_engine #(
    .T_RST_LOW (T_RST_LOW),
    .T_PRES_LO (T_PRES_LO),
    .T_PRES_HI (T_PRES_HI),
    .T_SLOT    (T_SLOT),
    .T_SHORT   (T_SHORT),
    .T_SAMPLE  (T_SAMPLE),
    .T_REC     (T_REC)
  ) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (slot_start),
    .kind     (slot_kind),
    .tick     (us_tick),
    .line_lvl (line_lvl),
    .pull     (line_pull),
    .done     (slot_done),
    .bit_smp  (slot_bit),
    .pres     (slot_pres)
  );
endmodule

// File: rtl/ow_master_chk.sv
module ow_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [2:0] cmd_op,
  input logic       busy,
  input logic       rsp_valid,
  input logic       line_pull,
  input logic       slot_start,
  input logic       slot_done
);
  a_r7_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line_pull);

  a_r8_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (cmd_op <= 3'd4)) |=> busy);

  a_r8_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r8_rsp_when_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!busy && $past(busy)));

  a_r9_unknown_op_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (cmd_op > 3'd4)) |=> (!busy && !line_pull));

  a_r4_next_slot_from_release: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start && busy) |-> !line_pull);

  a_r8_done_inside_command: assert property (@(posedge clk) disable iff (!rst_n)
    slot_done |-> busy);
endmodule

bind ow_master ow_master_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_op     (cmd_op),
  .busy       (busy),
  .rsp_valid  (rsp_valid),
  .line_pull  (line_pull),
  .slot_start (slot_start),
  .slot_done  (slot_done)
);

// File: tb/ow_master_test.sv
module ow_master_test;
  localparam int K = 4;  // clocks per microsecond in this bench

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [2:0] cmd_op;
  logic [7:0] cmd_data;
  logic       cmd_ready, busy, rsp_valid, rsp_presence, line_pull;
  logic [7:0] rsp_data;
  logic       dev_pull = 1'b0;
  wire        line_in = !(line_pull || dev_pull);

  always #4 clk = ~clk;

  ow_master #(.CLKS_PER_US(K)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_presence(rsp_presence), .line_in(line_in),
    .line_pull(line_pull)
  );

  int n_chk = 0;
  int n_err = 0;

  // Line observer and device model, updated on falling clock edges only.
  int   n_slots = 0;
  int   low_len [64];
  int   gap_before [64];
  logic at30 [64];
  int   lowcnt = 0, gapcnt = 1000000, since = 0;
  logic pl_d = 1'b0;
  int   dev_mode = 0;  // 0 silent, 1 presence responder, 2 read responder
  logic [7:0] dev_byte = 8'h00;
  int   dev_bit = 0, p_start = 0, p_len = 0, dev_wait = 0, dev_hold = 0;

  always @(negedge clk) begin
    logic [5:0] ix;
    if (dev_wait > 0) begin
      dev_wait--;
      if (dev_wait == 0) dev_hold = p_len * K;
    end else if (dev_hold > 0) begin
      dev_hold--;
    end
    if (line_pull && !pl_d) begin
      ix = n_slots[5:0];
      gap_before[ix] = gapcnt;
      lowcnt = 1;
      since = 1;
      n_slots++;
      if (dev_mode == 2) begin
        if (!dev_byte[dev_bit[2:0]]) dev_hold = 30 * K;
        dev_bit++;
      end
    end else begin
      since++;
      if (line_pull) lowcnt++;
    end
    ix = 6'(n_slots - 1);
    if (!line_pull && pl_d) begin
      low_len[ix] = lowcnt;
      gapcnt = 1;
      if (dev_mode == 1 && lowcnt >= 400 * K) dev_wait = p_start * K;
    end else if (!line_pull) begin
      gapcnt++;
    end
    if (since == 30 * K && n_slots > 0) at30[ix] = line_in;
    pl_d = line_pull;
    dev_pull = (dev_hold > 0);
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input string what, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic set_dev(input int mode, input logic [7:0] b, input int ps, input int pl);
    @(posedge clk);
    dev_mode = mode; dev_byte = b; dev_bit = 0;
    p_start = ps; p_len = pl; dev_wait = 0; dev_hold = 0;
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [7:0] d,
                         output logic [7:0] rd, output logic pr,
                         output int busy_cyc, output int first, output int nsl);
    int rsp_cnt, ready_bad, waited;
    logic fin, rsp_at_fall;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(posedge clk);
    first = n_slots;
    @(negedge clk);
    cmd_valid = 1'b0;
    busy_cyc = 0; rsp_cnt = 0; ready_bad = 0; waited = 0;
    fin = 1'b0; rsp_at_fall = 1'b0; rd = 8'h00; pr = 1'b0;
    while (!fin && waited < 10000) begin
      if (busy) begin
        busy_cyc++;
        if (cmd_ready) ready_bad++;
      end
      if (rsp_valid) begin
        rsp_cnt++; rd = rsp_data; pr = rsp_presence;
        if (!busy) rsp_at_fall = 1'b1;
        fin = 1'b1;
      end else if (!busy) begin
        fin = 1'b1;
      end
      waited++;
      @(negedge clk);
    end
    if (rsp_valid) rsp_cnt++;
    chk("R8", "ready low while busy (violations)", ready_bad, 0);
    chk("R8", "response pulses", rsp_cnt, 1);
    chk("R8", "response in cycle busy falls", int'(rsp_at_fall), 1);
    chk("R7", "line released after command", int'(line_pull), 0);
    @(posedge clk);
    nsl = n_slots - first;
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0; cmd_data = 8'h00;
    repeat (4) @(negedge clk);
    chk("R10", "line_pull in reset", int'(line_pull), 0);
    chk("R10", "busy in reset", int'(busy), 0);
    chk("R10", "rsp_valid in reset", int'(rsp_valid), 0);
    chk("R10", "cmd_ready in reset", int'(cmd_ready), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10", "line_pull after reset", int'(line_pull), 0);
    chk("R10", "cmd_ready after reset", int'(cmd_ready), 1);
  endtask

  task automatic t_bus_reset(input string tag, input int mode, input int ps, input int pl, input int exp_pres);
    logic [7:0] rd; logic pr; int bc, f, ns;
    set_dev(mode, 8'h00, ps, pl);
    run_cmd(3'd0, 8'h00, rd, pr, bc, f, ns);
    chk("R2", {tag, " presence"}, int'(pr), exp_pres);
    chk("R1", {tag, " slot count"}, ns, 1);
    chk("R11", {tag, " reset low clocks"}, low_len[6'(f)], 480 * K);
    chk_rng("R1", {tag, " busy clocks"}, bc, 720 * K, 720 * K + 2);
    chk("R1", {tag, " rsp_data"}, int'(rsp_data), 0);
  endtask

  task automatic t_write_bit(input logic b);
    logic [7:0] rd; logic pr; int bc, f, ns;
    set_dev(0, 8'h00, 0, 0);
    run_cmd(3'd1, {7'b0, b}, rd, pr, bc, f, ns);
    chk("R3", "write bit slots", ns, 1);
    chk("R3", "write bit low clocks", low_len[6'(f)], b ? 6 * K : 60 * K);
    chk("R3", "write bit level at 30us", int'(at30[6'(f)]), int'(b));
    chk_rng("R4", "write bit busy clocks", bc, 61 * K, 61 * K + 2);
  endtask

  task automatic t_write_byte(input logic [7:0] v);
    logic [7:0] rd; logic pr; int bc, f, ns; logic [7:0] seen;
    set_dev(0, 8'h00, 0, 0);
    run_cmd(3'd3, v, rd, pr, bc, f, ns);
    chk("R6", "write byte slots", ns, 8);
    seen = 8'h00;
    for (int i = 0; i < 8; i++) begin
      seen[i] = at30[6'(f + i)];
      chk("R3", "byte slot low clocks", low_len[6'(f + i)], v[i] ? 6 * K : 60 * K);
      if (i > 0) begin
        chk_rng("R4", "recovery clocks", gap_before[6'(f + i)], K, 62 * K);
        chk_rng("R4", "slot period clocks", low_len[6'(f + i - 1)] + gap_before[6'(f + i)], 61 * K, 61 * K + 1);
      end
    end
    chk("R6", "byte seen on line lsb first", int'(seen), int'(v));
    chk_rng("R4", "write byte busy clocks", bc, 8 * 61 * K, 8 * 61 * K + 8);
  endtask

  task automatic t_read_bit(input logic b);
    logic [7:0] rd; logic pr; int bc, f, ns;
    set_dev(2, {7'b0, b}, 0, 0);
    run_cmd(3'd2, 8'hFF, rd, pr, bc, f, ns);
    chk("R5", "read bit result", int'(rd), int'(b));
    chk("R5", "read bit low clocks", low_len[6'(f)], 6 * K);
    chk("R5", "read bit slots", ns, 1);
  endtask

  task automatic t_read_byte(input logic [7:0] v);
    logic [7:0] rd; logic pr; int bc, f, ns;
    set_dev(2, v, 0, 0);
    run_cmd(3'd4, 8'h00, rd, pr, bc, f, ns);
    chk("R6", "read byte result", int'(rd), int'(v));
    chk("R6", "read byte slots", ns, 8);
    for (int i = 0; i < 8; i++)
      chk("R5", "read byte slot low clocks", low_len[6'(f + i)], 6 * K);
  endtask

  task automatic t_bad_op(input logic [2:0] op);
    int bad, f;
    set_dev(0, 8'h00, 0, 0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = 8'hFF;
    @(posedge clk);
    f = n_slots;
    @(negedge clk);
    cmd_valid = 1'b0;
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      if (busy || rsp_valid || line_pull || !cmd_ready) bad++;
      @(negedge clk);
    end
    chk("R9", "activity after unknown op", bad, 0);
    @(posedge clk);
    chk("R9", "slots after unknown op", n_slots - f, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R8 watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset_state();
    t_bus_reset("mid pulse", 1, 30, 120, 1);
    t_bus_reset("no device", 0, 0, 0, 0);
    t_bus_reset("early pulse", 1, 10, 40, 0);
    t_bus_reset("late pulse", 1, 200, 100, 1);
    t_write_bit(1'b1);
    t_write_bit(1'b0);
    t_write_byte(8'hA5);
    t_write_byte(8'h3E);
    t_read_bit(1'b0);
    t_read_bit(1'b1);
    t_read_byte(8'h3C);
    t_read_byte(8'hC1);
    t_bad_op(3'd6);
    t_bad_op(3'd5);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule